// File: doc/BRIEF.md
# Flash Burst Read Configuration and Latency Controller

This block sits between a flash read port and the memory array. It holds a 16-bit read configuration word that picks one of two read styles: a page style, where data follows the address strobe without waiting, and a synchronous burst style, where a programmable number of clock cycles passes before the first word and a burst of words then follows on consecutive clocks. The host writes the configuration word with a strobe and can read it back through the identifier read space.

Each read access starts on a clock edge where the active-low address strobe is sampled low. The block captures the address and the configuration in force at that edge, and then drives the array address, the data bus and a data-valid flag for the whole access. Array bursts step the address once per word and wrap inside an aligned block of the burst length. Reads of the configuration word are non-array reads: in burst style the same word repeats for the whole burst, while in page style only the first word is valid. The array itself is outside the block and answers the array address combinationally on a data input.

Top module: `burst_rdcfg_ctrl`

## Requirements
- R1: A write strobe loads all 16 bits of the configuration word, and an identifier-space read (id_sel high) at offset 5 returns exactly that word, as captured when the access began.
- R2: Reset forces data-valid low and sets the configuration word to 16'hB807 (page style, latency code 7, continuous burst code).
- R3: Bit 15 of the configuration word selects the read style: 1 is page style, 0 is synchronous burst style.
- R4: In burst style, with the address strobe sampled low at edge E0, data-valid is low after edges E0 to E(L-1) and first goes high after edge EL, where L is the decoded latency.
- R5: The latency code sits in bits 14:11; codes 2 to 7 give that latency, and every other code gives latency 7.
- R6: The burst-length code sits in bits 2:0: 3'b001 gives 4 words, 3'b010 gives 8, 3'b011 gives 16, any other code is continuous; a finite burst keeps data-valid high for exactly that many consecutive cycles, then low.
- R7: A continuous burst keeps data-valid high and the array address counting up linearly, without wrapping, until the next access begins.
- R8: In a finite array burst, word k addresses the aligned block of the burst length that holds the start address, at offset (start + k) modulo the length, and the data bus carries the array data for that address.
- R9: A configuration-word read in burst style puts the same word on the data bus for every word of the burst.
- R10: In page style an array read is valid from the edge that captures the address, for PAGE_WORDS consecutive words whose addresses wrap inside the aligned page.
- R11: In page style an identifier-space read keeps data-valid high for only its first word.
- R12: An identifier-space read at any offset other than 5 returns all zeros, with the same timing as a configuration-word read.
- R13: A new address strobe ends any access in progress and starts a new one; a configuration write during an access does not change that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| adv_n | input | 1 | Active-low address strobe; sampled low starts an access |
| addr | input | AW | Start address, or identifier offset when id_sel is high |
| id_sel | input | 1 | Access targets the identifier space instead of the array |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_value | input | 16 | Configuration word to load |
| array_addr | output | AW | Word address presented to the array |
| array_data | input | DW | Array word for array_addr |
| dq | output | DW | Read data, zero while not valid |
| dq_valid | output | 1 | Data bus carries a valid word |

## Verification
The main read path is driven with a vector table that sweeps both read styles, every burst-length code, in-range and out-of-range latency codes, start addresses at the middle and edge of aligned blocks, and array, configuration and other identifier reads; comparing each sample against an address model separates wrapping from linear stepping and latency from burst length. Out-of-range latency codes tell clamping apart from truncation of the field. Directed cases then interrupt a burst with a new strobe, rewrite the configuration mid-access to show the access keeps the settings captured at its start, and reset during a continuous burst to show the word returns to its reset value.

// File: rtl/rdcfg_pkg.sv
package rdcfg_pkg;

   localparam int CFG_W       = 16;
   localparam int MODE_BIT    = 15;
   localparam int LAT_HI      = 14;
   localparam int LAT_LO      = 11;
   localparam int LEN_HI      = 2;
   localparam int LEN_LO      = 0;
   localparam int LAT_MIN     = 2;
   localparam int LAT_MAX     = 7;
   localparam int LAT_W       = $clog2(LAT_MAX + 1);
   localparam int LEN_MAX     = 16;
   localparam int BLEN_W      = $clog2(LEN_MAX) + 1;
   localparam int ID_CFG_OFS  = 5;
   localparam logic [CFG_W-1:0] CFG_RESET = 16'hB807;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_WAIT,
      ST_DATA
   } seq_st_t;

   typedef enum logic [1:0] {
      SRC_ARRAY,
      SRC_CFG,
      SRC_ZERO
   } rd_src_t;

   typedef struct packed {
      logic              page_mode;
      logic [LAT_W-1:0]  lat;
      logic              cont;
      logic [BLEN_W-1:0] blen;
   } rd_cfg_t;

   function automatic logic [LAT_W-1:0] lat_of(input logic [LAT_HI-LAT_LO:0] code);
      if (code >= 4'(LAT_MIN) && code <= 4'(LAT_MAX))
         return code[LAT_W-1:0];
      return LAT_W'(LAT_MAX);
   endfunction

endpackage

// File: rtl/rdcfg_store.sv
module rdcfg_store
   import rdcfg_pkg::*;
#(
   parameter int                 W     = CFG_W,
   parameter logic [CFG_W-1:0]   RSTV  = CFG_RESET
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= W'(RSTV);
      else if (wr)
         q <= wdata;
   end

   p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> q == $past(wdata));

   p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(q));

endmodule

// File: rtl/rdcfg_decode.sv
module rdcfg_decode
   import rdcfg_pkg::*;
#(
   parameter int W = CFG_W
)(
   input  logic [W-1:0] cfg,
   output rd_cfg_t      dec
);

   logic [LEN_HI-LEN_LO:0] len_code;

   assign len_code      = cfg[LEN_HI:LEN_LO];
   assign dec.page_mode = cfg[MODE_BIT];
   assign dec.lat       = lat_of(cfg[LAT_HI:LAT_LO]);

   always_comb begin
      dec.cont = 1'b0;
      dec.blen = '0;
      case (len_code)
         3'b001:  dec.blen = BLEN_W'(4);
         3'b010:  dec.blen = BLEN_W'(8);
         3'b011:  dec.blen = BLEN_W'(16);
         default: dec.cont = 1'b1;
      endcase
   end

   always_comb begin
      p_lat_range_r5: assert (dec.lat >= LAT_W'(LAT_MIN) && dec.lat <= LAT_W'(LAT_MAX));
   end

endmodule

// File: rtl/rdcfg_addr_gen.sv
module rdcfg_addr_gen #(
   parameter int AW = 24
)(
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] beat,
   input  logic [AW-1:0] wrap_mask,
   output logic [AW-1:0] addr
);

   logic [AW-1:0] sum;

   assign sum = base + beat;

   for (genvar i = 0; i < AW; i++) begin : g_bit
      assign addr[i] = wrap_mask[i] ? sum[i] : base[i];
   end

endmodule

// File: rtl/rdcfg_seq.sv
module rdcfg_seq
   import rdcfg_pkg::*;
#(
   parameter int AW         = 24,
   parameter int PAGE_WORDS = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [AW-1:0]     addr,
   input  logic              id_sel,
   input  rd_cfg_t           dec,
   input  logic [CFG_W-1:0]  cfg_q,
   output logic              data_on,
   output logic [AW-1:0]     base,
   output logic [AW-1:0]     beat,
   output logic [AW-1:0]     wrap_mask,
   output rd_src_t           src,
   output logic [CFG_W-1:0]  snap,
   output logic              page_q,
   output logic              cont_q
);

   localparam logic [BLEN_W-1:0] PAGE_LEN = BLEN_W'(PAGE_WORDS);
   localparam logic [AW-1:0]     ID_OFS   = AW'(ID_CFG_OFS);

   seq_st_t            st;
   logic [LAT_W-1:0]   wcnt;
   logic [LAT_W-1:0]   lat_q;
   logic [BLEN_W-1:0]  words_q;
   logic [AW-1:0]      last_beat;

   assign last_beat = AW'(words_q - 1'b1);
   assign wrap_mask = cont_q ? '1 : last_beat;
   assign data_on   = (st == ST_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         wcnt    <= '0;
         lat_q   <= LAT_W'(LAT_MAX);
         words_q <= '0;
         base    <= '0;
         beat    <= '0;
         src     <= SRC_ZERO;
         snap    <= '0;
         page_q  <= 1'b1;
         cont_q  <= 1'b0;
      end else if (capture) begin
         base   <= addr;
         beat   <= '0;
         snap   <= cfg_q;
         lat_q  <= dec.lat;
         page_q <= dec.page_mode;
         if (!id_sel)
            src <= SRC_ARRAY;
         else if (addr == ID_OFS)
            src <= SRC_CFG;
         else
            src <= SRC_ZERO;
         if (dec.page_mode) begin
            st      <= ST_DATA;
            cont_q  <= 1'b0;
            words_q <= id_sel ? BLEN_W'(1) : PAGE_LEN;
         end else begin
            st      <= ST_WAIT;
            wcnt    <= dec.lat;
            cont_q  <= dec.cont;
            words_q <= dec.blen;
         end
      end else begin
         case (st)
            ST_WAIT: begin
               if (wcnt == LAT_W'(1))
                  st <= ST_DATA;
               else
                  wcnt <= wcnt - 1'b1;
            end
            ST_DATA: begin
               beat <= beat + 1'b1;
               if (!cont_q && beat == last_beat)
                  st <= ST_IDLE;
            end
            default: ;
         endcase
      end
   end

   // Cycles since the last capture, kept apart from the latency counter.
   logic [3:0] since_cap;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         since_cap <= '0;
      else if (capture)
         since_cap <= '0;
      else if (since_cap != 4'hF)
         since_cap <= since_cap + 1'b1;
   end

   p_first_word_lat_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(data_on) && !page_q) |-> since_cap == 4'(lat_q));

   p_burst_in_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (data_on && !cont_q) |-> beat < AW'(words_q));

   p_page_no_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (capture && dec.page_mode) |=> data_on);

endmodule

// File: rtl/burst_rdcfg_ctrl.sv
module burst_rdcfg_ctrl
   import rdcfg_pkg::*;
#(
   parameter int AW         = 24,
   parameter int DW         = 16,
   parameter int PAGE_WORDS = 4
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv_n,
   input  logic [AW-1:0] addr,
   input  logic          id_sel,
   input  logic          cfg_wr,
   input  logic [15:0]   cfg_value,
   output logic [AW-1:0] array_addr,
   input  logic [DW-1:0] array_data,
   output logic [DW-1:0] dq,
   output logic          dq_valid
);

   if (DW < CFG_W) begin : g_chk_dw
      $error("burst_rdcfg_ctrl: DW must hold the configuration word");
   end
   if (AW < 8) begin : g_chk_aw
      $error("burst_rdcfg_ctrl: AW must be at least 8");
   end
   if (PAGE_WORDS < 2 || PAGE_WORDS > LEN_MAX ||
       (PAGE_WORDS & (PAGE_WORDS - 1)) != 0) begin : g_chk_page
      $error("burst_rdcfg_ctrl: PAGE_WORDS must be a power of two from 2 to 16");
   end

   logic [CFG_W-1:0] cfg_q;
   rd_cfg_t          dec;
   logic             data_on;
   logic [AW-1:0]    base;
   logic [AW-1:0]    beat;
   logic [AW-1:0]    wrap_mask;
   rd_src_t          src;
   logic [CFG_W-1:0] snap;
   logic             page_q;
   logic             cont_q;
   logic [DW-1:0]    cfg_word;

   rdcfg_store #(.W(CFG_W), .RSTV(CFG_RESET)) i_store (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (cfg_wr),
      .wdata (cfg_value),
      .q     (cfg_q)
   );

   rdcfg_decode #(.W(CFG_W)) i_decode (
      .cfg (cfg_q),
      .dec (dec)
   );

   rdcfg_seq #(.AW(AW), .PAGE_WORDS(PAGE_WORDS)) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture   (!adv_n),
      .addr      (addr),
      .id_sel    (id_sel),
      .dec       (dec),
      .cfg_q     (cfg_q),
      .data_on   (data_on),
      .base      (base),
      .beat      (beat),
      .wrap_mask (wrap_mask),
      .src       (src),
      .snap      (snap),
      .page_q    (page_q),
      .cont_q    (cont_q)
   );

   rdcfg_addr_gen #(.AW(AW)) i_addr_gen (
      .base      (base),
      .beat      (beat),
      .wrap_mask (wrap_mask),
      .addr      (array_addr)
   );

   if (DW == CFG_W) begin : g_cfg_exact
      assign cfg_word = snap;
   end else begin : g_cfg_pad
      assign cfg_word = {{(DW - CFG_W){1'b0}}, snap};
   end

   assign dq_valid = data_on;

   always_comb begin
      dq = '0;
      if (data_on) begin
         case (src)
            SRC_ARRAY: dq = array_data;
            SRC_CFG:   dq = cfg_word;
            default:   dq = '0;
         endcase
      end
   end

   p_wrap_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_valid && src == SRC_ARRAY) |-> ((array_addr ^ base) & ~wrap_mask) == '0);

   p_cfg_repeat_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_valid && $past(dq_valid) && $past(adv_n) && src == SRC_CFG) |-> $stable(dq));

   p_page_id_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_valid && page_q && src != SRC_ARRAY) |=> (!dq_valid || !$past(adv_n)));

   p_zero_id_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_valid && src == SRC_ZERO) |-> dq == '0);

endmodule

// File: tb/test_burst_rdcfg_ctrl.sv
module test_burst_rdcfg_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int AW   = 24;
   localparam int DW   = 16;
   localparam int PAGE = 4;
   localparam int NVEC = 10;

   localparam logic [15:0] VEC_CFG [NVEC] = '{
      16'h1001, 16'h2802, 16'h3803, 16'h0001, 16'h6001,
      16'h1A52, 16'h8001, 16'hC3A4, 16'h1001, 16'h2007 };
   localparam bit VEC_ID [NVEC] = '{ 0, 0, 0, 0, 0, 1, 0, 1, 1, 0 };
   localparam logic [AW-1:0] VEC_ADDR [NVEC] = '{
      24'h000123, 24'h00045D, 24'h0000FA, 24'h000010, 24'h000037,
      24'h000005, 24'h000202, 24'h000005, 24'h000003, 24'h00FFFE };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          adv_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic          id_sel = 1'b0;
   logic          cfg_wr = 1'b0;
   logic [15:0]   cfg_value = '0;
   logic [AW-1:0] array_addr;
   logic [DW-1:0] array_data;
   logic [DW-1:0] dq;
   logic          dq_valid;

   int checks = 0;
   int fails  = 0;
   logic [15:0] reg_model = 16'hB807;

   always #(CLK_PERIOD / 2) clk = ~clk;

   // Array model: each word is its address folded with a fixed pattern.
   assign array_data = array_addr[15:0] ^ 16'hA5C3;

   burst_rdcfg_ctrl #(.AW(AW), .DW(DW), .PAGE_WORDS(PAGE)) i_burst_rdcfg_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .adv_n      (adv_n),
      .addr       (addr),
      .id_sel     (id_sel),
      .cfg_wr     (cfg_wr),
      .cfg_value  (cfg_value),
      .array_addr (array_addr),
      .array_data (array_data),
      .dq         (dq),
      .dq_valid   (dq_valid)
   );

   function automatic int exp_lat(logic [15:0] c);
      int lc = int'(c[14:11]);
      return (lc >= 2 && lc <= 7) ? lc : 7;
   endfunction

   function automatic int exp_len(logic [15:0] c);
      case (c[2:0])
         3'b001:  return 4;
         3'b010:  return 8;
         3'b011:  return 16;
         default: return 0;
      endcase
   endfunction

   function automatic logic [AW-1:0] wrapa(logic [AW-1:0] a, int b, int len);
      logic [AW-1:0] s = a + AW'(b);
      logic [AW-1:0] m;
      if (len == 0) return s;
      m = AW'(len - 1);
      return (a & ~m) | (s & m);
   endfunction

   task automatic check_simple(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_k(int k, logic [15:0] acc, bit id, logic [AW-1:0] a, string extra);
      bit   page = acc[15];
      int   lat  = exp_lat(acc);
      int   len  = exp_len(acc);
      int   b;
      bit   ev;
      logic [15:0]   ed = '0;
      logic [AW-1:0] ea;
      string tag = {extra, " R3"};
      if (page) begin
         b  = k;
         ev = (k < (id ? 1 : PAGE));
         tag = {tag, id ? " R11 R1" : " R10"};
      end else begin
         b  = k - lat;
         ev = (k >= lat) && (len == 0 || b < len);
         tag = {tag, " R4 R6"};
         if (id) tag = {tag, (a == 24'd5) ? " R9 R1" : " R12"};
         else    tag = {tag, (len == 0) ? " R7" : " R8"};
         if (int'(acc[14:11]) < 2 || int'(acc[14:11]) > 7) tag = {tag, " R5"};
      end
      if (!id) begin
         ea = wrapa(a, b, page ? PAGE : len);
         ed = ea[15:0] ^ 16'hA5C3;
      end else if (a == 24'd5) begin
         ed = acc;
      end
      checks++;
      if (dq_valid !== ev || (ev && dq !== ed)) begin
         fails++;
         $display("FAIL%s k=%0d actual valid=%b dq=%h expected valid=%b dq=%h",
                  tag, k, dq_valid, dq, ev, ed);
      end
   endtask

   // All tasks start and end just after a falling clock edge.
   task automatic do_cfg(logic [15:0] v);
      cfg_wr = 1'b1;
      cfg_value = v;
      @(negedge clk);
      cfg_wr = 1'b0;
      reg_model = v;
      @(negedge clk);
   endtask

   task automatic capture(bit id, logic [AW-1:0] a);
      adv_n  = 1'b0;
      id_sel = id;
      addr   = a;
      @(negedge clk);
      adv_n  = 1'b1;
   endtask

   task automatic run_access(bit wr_first, logic [15:0] v, bit id, logic [AW-1:0] a, string extra);
      logic [15:0] acc;
      int n;
      if (wr_first) do_cfg(v);
      acc = reg_model;
      capture(id, a);
      if (acc[15]) n = 6;
      else n = exp_lat(acc) + ((exp_len(acc) == 0) ? 20 : exp_len(acc)) + 3;
      for (int k = 0; k < n; k++) begin
         check_k(k, acc, id, a, extra);
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check_simple(dq_valid === 1'b0, "R2 valid in reset", 32'(dq_valid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check_simple(dq_valid === 1'b0, "R2 valid after reset", 32'(dq_valid), 32'd0);
      // Reset word read in page style: one valid word of 16'hB807.
      run_access(1'b0, 16'h0, 1'b1, 24'd5, "R2");

      // Table of accesses walked by one loop.
      for (int i = 0; i < NVEC; i++)
         run_access(1'b1, VEC_CFG[i], VEC_ID[i], VEC_ADDR[i], "");

      // R13: a new strobe interrupts a 16-word burst after four words.
      do_cfg(16'h1003);
      capture(1'b0, 24'h000040);
      for (int k = 0; k < 6; k++) begin
         check_k(k, 16'h1003, 1'b0, 24'h000040, "R13");
         if (k < 5) @(negedge clk);
      end
      capture(1'b0, 24'h000080);
      for (int k = 0; k < 8; k++) begin
         check_k(k, 16'h1003, 1'b0, 24'h000080, "R13");
         @(negedge clk);
      end

      // R13: configuration write during an access leaves that access alone.
      do_cfg(16'h1001);
      capture(1'b0, 24'h000030);
      for (int k = 0; k < 8; k++) begin
         check_k(k, 16'h1001, 1'b0, 24'h000030, "R13");
         if (k == 0) begin cfg_wr = 1'b1; cfg_value = 16'h8000; end
         if (k == 1) cfg_wr = 1'b0;
         @(negedge clk);
      end
      reg_model = 16'h8000;
      run_access(1'b0, 16'h0, 1'b1, 24'd5, "R13");

      // R2: reset in the middle of a continuous burst.
      do_cfg(16'h1007);
      capture(1'b0, 24'h000100);
      for (int k = 0; k < 8; k++) begin
         check_k(k, 16'h1007, 1'b0, 24'h000100, "R7");
         @(negedge clk);
      end
      rst_n = 1'b0;
      reg_model = 16'hB807;
      #1;
      check_simple(dq_valid === 1'b0, "R2 valid on reset mid-burst", 32'(dq_valid), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      run_access(1'b0, 16'h0, 1'b1, 24'd5, "R2");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule